// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has a low and a high count byte. Each channel counts either a one-cycle machine tick or falling edges of an external count input, and an external gate pin can hold it stopped. A single shared configuration byte selects the behaviour of both channels. Each of its nibbles picks one of four counting structures: a 13-bit counter with a 5-bit prescaler, a 16-bit counter, an 8-bit counter that reloads from the high byte, or a split mode.

In split mode, channel 0's two bytes become independent 8-bit timers and channel 1 freezes. When a channel overflows it raises a flag. That flag drops when the interrupt controller acknowledges it, and software can also write it. Software reaches every piece of state through a byte-wide register port with combinational read data.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register (configuration, control, the four count bytes) reads 00h and both overflow flags are 0.
- R2: Register addresses are 0 config, 1 control, 2 ch0 low, 3 ch0 high, 4 ch1 low, 5 ch1 high. Control bit 0 is the ch0 run bit, bit 1 the ch1 run bit, bit 2 the ch0 flag and bit 3 the ch1 flag. A write to a count byte in the same cycle as a count event stores the written value.
- R3: Config bits [3:0] belong to ch0 and bits [7:4] to ch1. Within each nibble, [1:0] is the mode, bit 2 selects counting external edges (1) or ticks (0), and bit 3 enables gating. A channel whose run bit is 0 does not count.
- R4: In tick mode a running channel advances once per cycle in which tick_i is 1.
- R5: In edge mode a running channel advances on a tick at which the count input is 0 and was 1 at the previous tick. An input held low advances nothing further.
- R6: With gating enabled, a channel advances only while its gate input is 1.
- R7: Mode 0 increments only low bits [4:0]. When they wrap from 1Fh the high byte increments, and a high byte wrapping from FFh sets the flag. Low bits [7:5] are kept.
- R8: Mode 1 counts the 16-bit pair {high, low} and sets the flag on the wrap from FFFFh to 0000h.
- R9: Mode 2 increments the low byte. When it wraps from FFh it loads the high byte, which stays unchanged, and the flag is set.
- R10: With ch0 in mode 3, ch0 low counts under ch0's controls and sets ch0's flag. Ch0 high counts ticks while ch1's run bit is 1 and sets ch1's flag. Ch1 in mode 3 holds its count.
- R11: An acknowledge clears a flag. An overflow in the same cycle as an acknowledge leaves the flag set. A control write sets or clears the flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | one-cycle machine tick |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 3 | register address |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data, combinational on addr_i |
| cnt_pin_i | input | 2 | external count inputs, one per channel |
| gate_pin_i | input | 2 | external gate inputs, one per channel |
| ack_i | input | 2 | interrupt acknowledge, one per flag |
| ovf_o | output | 2 | overflow flags |

## Verification
Every count byte and flag is a register. Its new value is due on the same rising edge that sees tick_i, a write or an acknowledge, so it can be read back on the next falling edge. The edge-mode input is compared against a sample taken at the previous tick, so one tick is needed to arm the detector and the following tick does the counting. The bench changes inputs only on falling edges, holds tick_i for whole cycles, and reads rdata_o one time step after setting addr_i. It reads ovf_o on the falling edge after the counting edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13  = 2'd0,
    MODE_16  = 2'd1,
    MODE_8R  = 2'd2,
    MODE_SPL = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      edge_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [2:0] A_CFG = 3'd0;
  localparam logic [2:0] A_CTL = 3'd1;
  localparam logic [2:0] A_LO0 = 3'd2;
  localparam logic [2:0] A_HI0 = 3'd3;
  localparam logic [2:0] A_LO1 = 3'd4;
  localparam logic [2:0] A_HI1 = 3'd5;
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic gate_en_i,
  input  logic gate_i,
  input  logic edge_sel_i,
  input  logic pin_i,
  output logic evt_o
);
  logic smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smp_q <= 1'b0;
    else if (tick_i) smp_q <= pin_i;
  end

  logic enabled;
  assign enabled = run_i & (~gate_en_i | gate_i);
  // falling edge across two successive tick samples
  assign evt_o = tick_i & enabled & (~edge_sel_i | (smp_q & ~pin_i));
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5,
  parameter bit SPLIT = 1'b0
) (
  input  tmr_mode_e       mode_i,
  input  logic            evt_i,
  input  logic            hi_evt_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  output logic [DW-1:0]   lo_o,
  output logic [DW-1:0]   hi_o,
  output logic            ovf_o,
  output logic            hi_ovf_o
);
  always_comb begin
    lo_o     = lo_i;
    hi_o     = hi_i;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    unique case (mode_i)
      MODE_13: if (evt_i) begin
        lo_o[PRE_W-1:0] = lo_i[PRE_W-1:0] + 1'b1;
        if (&lo_i[PRE_W-1:0]) begin
          hi_o  = hi_i + 1'b1;
          ovf_o = &hi_i;
        end
      end
      MODE_16: if (evt_i) begin
        {hi_o, lo_o} = {hi_i, lo_i} + 1'b1;
        ovf_o        = &{hi_i, lo_i};
      end
      MODE_8R: if (evt_i) begin
        lo_o  = (&lo_i) ? hi_i : lo_i + 1'b1;
        ovf_o = &lo_i;
      end
      MODE_SPL: if (SPLIT) begin
        if (evt_i) begin
          lo_o  = lo_i + 1'b1;
          ovf_o = &lo_i;
        end
        if (hi_evt_i) begin
          hi_o     = hi_i + 1'b1;
          hi_ovf_o = &hi_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    cnt_pin_i,
  input  logic [1:0]    gate_pin_i,
  input  logic [1:0]    ack_i,
  output logic [1:0]    ovf_o
);
  localparam int NCH = 2;

  logic [DW-1:0] cfg_q;
  logic [NCH-1:0] run_q, ovf_q;
  logic [DW-1:0] lo_q [NCH];
  logic [DW-1:0] hi_q [NCH];
  logic [DW-1:0] lo_n [NCH];
  logic [DW-1:0] hi_n [NCH];
  logic [NCH-1:0] evt, ovf_c, hi_ovf_c, ovf_set;
  tmr_cfg_t cfg [NCH];
  logic split, split_hi_evt;

  assign split        = cfg[0].mode == MODE_SPL;
  assign split_hi_evt = tick_i & run_q[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg[i] = tmr_cfg_t'(cfg_q[4*i +: 4]);

    tmr_evt u_evt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .run_i      (run_q[i]),
      .gate_en_i  (cfg[i].gate_en),
      .gate_i     (gate_pin_i[i]),
      .edge_sel_i (cfg[i].edge_sel),
      .pin_i      (cnt_pin_i[i]),
      .evt_o      (evt[i])
    );

    tmr_cnt #(.DW(DW), .PRE_W(PRE_W), .SPLIT(i == 0)) u_cnt (
      .mode_i   (cfg[i].mode),
      .evt_i    (evt[i]),
      .hi_evt_i (split_hi_evt),
      .lo_i     (lo_q[i]),
      .hi_i     (hi_q[i]),
      .lo_o     (lo_n[i]),
      .hi_o     (hi_n[i]),
      .ovf_o    (ovf_c[i]),
      .hi_ovf_o (hi_ovf_c[i])
    );
  end

  // in split mode ch0 high byte owns ch1's flag
  assign ovf_set[0] = ovf_c[0];
  assign ovf_set[1] = split ? hi_ovf_c[0] : ovf_c[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= '0;
      ovf_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= lo_n[i];
        hi_q[i] <= hi_n[i];
        if (ovf_set[i])    ovf_q[i] <= 1'b1;
        else if (ack_i[i]) ovf_q[i] <= 1'b0;
      end
      if (wr_en_i) begin
        unique case (addr_i)
          A_CFG: cfg_q <= wdata_i;
          A_CTL: begin
            run_q <= wdata_i[1:0];
            ovf_q <= wdata_i[3:2];
          end
          A_LO0: lo_q[0] <= wdata_i;
          A_HI0: hi_q[0] <= wdata_i;
          A_LO1: lo_q[1] <= wdata_i;
          A_HI1: hi_q[1] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_CTL:   rdata_o = DW'({ovf_q, run_q});
      A_LO0:   rdata_o = lo_q[0];
      A_HI0:   rdata_o = hi_q[0];
      A_LO1:   rdata_o = lo_q[1];
      A_HI1:   rdata_o = hi_q[1];
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic [1:0]    ack_i,
  input logic [1:0]    ovf_o,
  input logic [DW-1:0] cfg_q,
  input logic [1:0]    run_q,
  input logic [DW-1:0] lo0,
  input logic [DW-1:0] hi0,
  input logic [DW-1:0] lo1,
  input logic [DW-1:0] hi1
);
  AST_CH1_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[5:4] == 2'd3 && !wr_en_i) |=> $stable({hi1, lo1})); // R10

  AST_CH0_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && cfg_q[1:0] != 2'd3 && !wr_en_i) |=> $stable({hi0, lo0})); // R3

  AST_FLAG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o[0]) |-> $past(tick_i || wr_en_i)); // R11

  AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !tick_i && !wr_en_i) |=> !ovf_o[0]); // R11

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[1:0] == 2'd2 && $rose(ovf_o[0]) && !$past(wr_en_i)) |-> lo0 == hi0); // R9
endmodule

bind tmr_pair tmr_pair_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .ack_i   (ack_i),
  .ovf_o   (ovf_o),
  .cfg_q   (cfg_q),
  .run_q   (run_q),
  .lo0     (lo_q[0]),
  .hi0     (hi_q[0]),
  .lo1     (lo_q[1]),
  .hi1     (hi_q[1])
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] ovf;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tmr_pair dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .cnt_pin_i  (cnt_pin),
    .gate_pin_i (gate_pin),
    .ack_i      (ack),
    .ovf_o      (ovf)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic tk(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) rd("R1", 3'(a), 8'h00);
    chk("R1", {6'd0, ovf}, 8'h00);
  endtask

  task automatic t_m16;
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'hFF);
    tk(2);
    rd("R3 no run", 3'd2, 8'hFE);
    wr(3'd1, 8'h01);
    tk(1);
    rd("R4", 3'd2, 8'hFF);
    tk(1);
    rd("R8 lo", 3'd2, 8'h00);
    rd("R8 hi", 3'd3, 8'h00);
    chk("R8 flag", {6'd0, ovf}, 8'h01);
    rd("R2 ctl", 3'd1, 8'h05);
  endtask

  task automatic t_flags;
    ack = 2'b01;
    @(negedge clk);
    ack = 2'b00;
    chk("R11 ack", {6'd0, ovf}, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    ack = 2'b01; tick = 1'b1;
    @(negedge clk);
    ack = 2'b00; tick = 1'b0;
    chk("R11 set beats ack", {6'd0, ovf}, 8'h01);
    wr(3'd1, 8'h01);
    chk("R11 sw clear", {6'd0, ovf}, 8'h00);
    wr(3'd1, 8'h05);
    chk("R11 sw set", {6'd0, ovf}, 8'h01);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_wr_wins;
    wr(3'd2, 8'h10);
    tick = 1'b1;
    wr(3'd2, 8'h80);
    tick = 1'b0;
    rd("R2 write wins", 3'd2, 8'h80);
  endtask

  task automatic t_m13;
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h12);
    tk(1);
    rd("R7 lo", 3'd2, 8'hE0);
    rd("R7 hi", 3'd3, 8'h13);
    chk("R7 no flag", {6'd0, ovf}, 8'h00);
    wr(3'd2, 8'h1F);
    wr(3'd3, 8'hFF);
    tk(1);
    rd("R7 wrap lo", 3'd2, 8'h00);
    rd("R7 wrap hi", 3'd3, 8'h00);
    chk("R7 flag", {6'd0, ovf}, 8'h01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_m8r;
    wr(3'd0, 8'h20);
    wr(3'd4, 8'hFE);
    wr(3'd5, 8'hF0);
    wr(3'd1, 8'h02);
    tk(1);
    rd("R9", 3'd4, 8'hFF);
    tk(1);
    rd("R9 reload", 3'd4, 8'hF0);
    rd("R9 hi kept", 3'd5, 8'hF0);
    chk("R9 flag", {6'd0, ovf}, 8'h02);
    tk(1);
    rd("R9 after", 3'd4, 8'hF1);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_edge;
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    cnt_pin[0] = 1'b1; tk(1);
    rd("R5 rise", 3'd2, 8'h00);
    cnt_pin[0] = 1'b0; tk(1);
    rd("R5 fall", 3'd2, 8'h01);
    tk(1);
    rd("R5 held low", 3'd2, 8'h01);
    cnt_pin[0] = 1'b1; tk(1);
    cnt_pin[0] = 1'b0; tk(1);
    rd("R5 second", 3'd2, 8'h02);
  endtask

  task automatic t_gate;
    wr(3'd0, 8'h09);
    wr(3'd2, 8'h00);
    gate_pin[0] = 1'b0; tk(3);
    rd("R6 gated off", 3'd2, 8'h00);
    gate_pin[0] = 1'b1; tk(3);
    rd("R6 gated on", 3'd2, 8'h03);
    gate_pin[0] = 1'b0;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_split;
    wr(3'd0, 8'h33);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'hFD);
    wr(3'd4, 8'h10);
    wr(3'd5, 8'h20);
    wr(3'd1, 8'h01);
    tk(2);
    rd("R10 lo0", 3'd2, 8'h00);
    rd("R10 hi0 idle", 3'd3, 8'hFD);
    chk("R10 flag0", {6'd0, ovf}, 8'h01);
    wr(3'd1, 8'h02);
    tk(3);
    rd("R10 hi0", 3'd3, 8'h00);
    rd("R10 lo0 idle", 3'd2, 8'h00);
    chk("R10 flag1", {6'd0, ovf}, 8'h02);
    rd("R10 ch1 lo", 3'd4, 8'h10);
    rd("R10 ch1 hi", 3'd5, 8'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_m16();
    t_flags();
    t_wr_wins();
    t_m13();
    t_m8r();
    t_edge();
    t_gate();
    t_split();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule